// File: doc/BRIEF.md
# Keyed Independent Watchdog Timer

This block is a watchdog that runs from a slow tick enable. The tick is a one-cycle pulse in the fast clock domain and stands in for a slow, separate oscillator. A 12-bit down-counter is stepped once every 2^(code+2) ticks, where the code comes from a divider register. When the counter steps past zero, the block raises a one-cycle reset request and reloads itself. Software keeps the timer from expiring by writing a service key before the counter runs out. Every control action goes through 16-bit magic values written to a single key register. Writes to the configuration registers are accepted only after an unlock key has been written.

New divider and reload values do not take effect at once. Each one passes through a fixed synchronisation delay of three ticks, and a status busy bit shows while it is still pending. An optional early-warning interrupt is raised when the counter steps down onto a programmable compare value. It stays raised until software writes an acknowledge bit.

The register bus is a plain single-cycle write strobe with address and data. Read data is combinational from the address.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is stopped and locked, and both outputs are low. Reads return 0 for the divider code at offset 0x04, 0xFFF for the reload value at 0x08, 0 for status at 0x0C and 0 for the early-warning register at 0x14.
- R2: Writing 0x5555 to the key register at 0x00 unlocks writes to 0x04, 0x08 and the compare and enable fields of 0x14. Writing 0x0000 locks them again. A write to those registers while locked leaves their read-back value unchanged.
- R3: A key write whose value is none of 0x5555, 0x0000, 0xCCCC or 0xAAAA changes nothing: it neither locks, unlocks, starts nor services the watchdog.
- R4: Writing 0xCCCC starts the watchdog from the applied reload value. While running, the counter steps down once every 2^(code+2) ticks, where the code is bits 2:0 of 0x04. Codes above 6 act as 6, so the divide is 256.
- R5: When the counter is at zero and takes another step, the reset output is high for exactly one clock. The counter then reloads, so successive expiries are (reload+1) x divide ticks apart.
- R6: Writing 0xAAAA loads the counter from the applied reload value and clears the divider phase. Servicing more often than the period prevents any reset.
- R7: Once started, the watchdog keeps running whatever keys are written afterwards. Only the reset input stops it.
- R8: An accepted divider write sets status bit 0. The bit clears on the third tick after the write, and from then on the new divide is used.
- R9: An accepted reload write sets status bit 1. The bit clears on the third tick after the write, and later loads use the new 12-bit value.
- R10: Register 0x14 holds a 12-bit compare value in bits 11:0 and an enable in bit 15. With the enable set, a counter step that lands on the compare value raises the early-warning output. The output then stays high until it is acknowledged.
- R11: Writing 0x14 with bit 14 set clears the early-warning output, whether the registers are locked or not.
- R12: Reads from the key register at 0x00 and from the unused window offset 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow time-base enable, one clock per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| wd_rst | output | 1 | One-cycle reset request on expiry |
| early_irq | output | 1 | Early-warning interrupt, held until acknowledged |

## Verification
The timer is measured by counting ticks from a start or service key until the reset pulse and until the early-warning edge. Tick streams range from every clock down to about one clock in three. A dense stream tells apart off-by-one errors in the divide and reload arithmetic. Sparse, irregular streams show that the counter moves only on ticks and never on clocks. Random divider codes, reload values and compare points separate a wrong power-of-two divide from a wrong reload or compare. Directed cases cover the key behaviour, the three-tick busy windows, the clamped top divider code and the phase cleared by servicing.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    // Magic values accepted by the key register
    localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [15:0] KEY_LOCK    = 16'h0000;
    localparam logic [15:0] KEY_START   = 16'hCCCC;
    localparam logic [15:0] KEY_SERVICE = 16'hAAAA;

    // Register byte offsets
    localparam logic [7:0] OFS_KEY    = 8'h00;
    localparam logic [7:0] OFS_DIV    = 8'h04;
    localparam logic [7:0] OFS_RELOAD = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h0C;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] OFS_EARLY  = 8'h14;

    // Bit positions
    localparam int EW_ACK_BIT       = 14;
    localparam int EW_EN_BIT        = 15;
    localparam int ST_DIV_BUSY_BIT  = 0;
    localparam int ST_RLD_BUSY_BIT  = 1;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_UNLOCK,
        CMD_LOCK,
        CMD_START,
        CMD_SERVICE
    } key_cmd_e;

endpackage

// File: rtl/wdt_key_ctrl.sv
module wdt_key_ctrl
    import keyed_wdt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              unlocked,
    output logic              running,
    output logic              load_now
);

    typedef struct packed {
        logic unlocked;
        logic running;
    } key_state_t;

    key_state_t st_d, st_q;
    key_cmd_e   cmd;

    always_comb begin
        cmd = CMD_NONE;
        if (key_wr) begin
            if (key_val == DATA_W'(KEY_UNLOCK))       cmd = CMD_UNLOCK;
            else if (key_val == DATA_W'(KEY_LOCK))    cmd = CMD_LOCK;
            else if (key_val == DATA_W'(KEY_START))   cmd = CMD_START;
            else if (key_val == DATA_W'(KEY_SERVICE)) cmd = CMD_SERVICE;
        end

        st_d = st_q;
        case (cmd)
            CMD_UNLOCK: st_d.unlocked = 1'b1;
            CMD_LOCK:   st_d.unlocked = 1'b0;
            CMD_START:  st_d.running  = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unlocked = st_q.unlocked;
    assign running  = st_q.running;
    assign load_now = (cmd == CMD_START) || (cmd == CMD_SERVICE);

endmodule

// File: rtl/wdt_sync_reg.sv
module wdt_sync_reg #(
    parameter int           W          = 12,
    parameter logic [W-1:0] RST_VAL    = '0,
    parameter int           SYNC_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         tick,
    output logic [W-1:0] staged,
    output logic [W-1:0] active,
    output logic         busy
);

    localparam int SC_W = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        logic [W-1:0]    staged;
        logic [W-1:0]    active;
        logic [SC_W-1:0] left;
        logic            busy;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.staged = wr_val;
            s_d.left   = SC_W'(SYNC_TICKS);
            s_d.busy   = 1'b1;
        end else if (s_q.busy && tick) begin
            if (s_q.left <= SC_W'(1)) begin
                s_d.active = s_q.staged;
                s_d.left   = '0;
                s_d.busy   = 1'b0;
            end else begin
                s_d.left = s_q.left - SC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.staged <= RST_VAL;
            s_q.active <= RST_VAL;
            s_q.left   <= '0;
            s_q.busy   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign staged = s_q.staged;
    assign active = s_q.active;
    assign busy   = s_q.busy;

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int CNT_W    = 12,
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              load,
    input  logic [CODE_W-1:0] div_code,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  cmp,
    input  logic              ew_en,
    input  logic              ack,
    output logic              expire,
    output logic              irq
);

    localparam int PC_W = MAX_CODE + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PC_W-1:0]  pcnt;
        logic             rst;
        logic             irq;
    } ctr_t;

    ctr_t c_d, c_q;

    logic [CODE_W-1:0] eff_code;
    logic [PC_W:0]     lim;
    logic              step;
    logic              hit_cmp;

    always_comb begin
        eff_code = (div_code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : div_code;
        lim      = ((PC_W+1)'(1) << (int'(eff_code) + 2)) - (PC_W+1)'(1);
        step     = run && tick && ({1'b0, c_q.pcnt} >= lim);
        hit_cmp  = 1'b0;

        c_d     = c_q;
        c_d.rst = 1'b0;
        if (load) begin
            c_d.cnt  = reload;
            c_d.pcnt = '0;
        end else if (run && tick) begin
            if (step) begin
                c_d.pcnt = '0;
                if (c_q.cnt == '0) begin
                    c_d.cnt = reload;
                    c_d.rst = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt - CNT_W'(1);
                    hit_cmp = ew_en && (c_d.cnt == cmp);
                end
            end else begin
                c_d.pcnt = c_q.pcnt + PC_W'(1);
            end
        end

        if (ack)     c_d.irq = 1'b0;
        if (hit_cmp) c_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt  <= '1;
            c_q.pcnt <= '0;
            c_q.rst  <= 1'b0;
            c_q.irq  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign expire = c_q.rst;
    assign irq    = c_q.irq;

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 12,
    parameter int CODE_W     = 3,
    parameter int MAX_CODE   = 6,
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_rst,
    output logic              early_irq
);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cmp;
    } ew_t;

    logic hit_key, hit_div, hit_rld, hit_early;
    logic unlocked, running, load_now;
    logic div_wr_req, ack_wr;
    logic [CODE_W-1:0] div_staged, div_active;
    logic [CNT_W-1:0]  rld_staged, rld_active;
    logic div_busy, rl_busy;
    ew_t  ew_d, ew_q;

    // Address decode
    assign hit_key    = bus_wr && (bus_addr == ADDR_W'(OFS_KEY));
    assign hit_div    = bus_wr && (bus_addr == ADDR_W'(OFS_DIV));
    assign hit_rld    = bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD));
    assign hit_early  = bus_wr && (bus_addr == ADDR_W'(OFS_EARLY));
    assign div_wr_req = hit_div;
    assign ack_wr     = hit_early && bus_wdata[EW_ACK_BIT];

    wdt_key_ctrl #(
        .DATA_W (DATA_W)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (hit_key),
        .key_val  (bus_wdata),
        .unlocked (unlocked),
        .running  (running),
        .load_now (load_now)
    );

    wdt_sync_reg #(
        .W          (CODE_W),
        .RST_VAL    ('0),
        .SYNC_TICKS (SYNC_TICKS)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (hit_div && unlocked),
        .wr_val (bus_wdata[CODE_W-1:0]),
        .tick   (tick),
        .staged (div_staged),
        .active (div_active),
        .busy   (div_busy)
    );

    wdt_sync_reg #(
        .W          (CNT_W),
        .RST_VAL    ('1),
        .SYNC_TICKS (SYNC_TICKS)
    ) u_rld (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (hit_rld && unlocked),
        .wr_val (bus_wdata[CNT_W-1:0]),
        .tick   (tick),
        .staged (rld_staged),
        .active (rld_active),
        .busy   (rl_busy)
    );

    // Early-warning configuration: takes effect immediately
    always_comb begin
        ew_d = ew_q;
        if (hit_early && unlocked) begin
            ew_d.cmp = bus_wdata[CNT_W-1:0];
            ew_d.en  = bus_wdata[EW_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ew_q <= '0;
        else        ew_q <= ew_d;
    end

    wdt_down_counter #(
        .CNT_W    (CNT_W),
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (running),
        .load     (load_now),
        .div_code (div_active),
        .reload   (rld_active),
        .cmp      (ew_q.cmp),
        .ew_en    (ew_q.en),
        .ack      (ack_wr),
        .expire   (wd_rst),
        .irq      (early_irq)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_DIV):    bus_rdata[CODE_W-1:0] = div_staged;
            ADDR_W'(OFS_RELOAD): bus_rdata[CNT_W-1:0]  = rld_staged;
            ADDR_W'(OFS_STATUS): begin
                bus_rdata[ST_DIV_BUSY_BIT] = div_busy;
                bus_rdata[ST_RLD_BUSY_BIT] = rl_busy;
            end
            ADDR_W'(OFS_EARLY): begin
                bus_rdata[CNT_W-1:0] = ew_q.cmp;
                bus_rdata[EW_EN_BIT] = ew_q.en;
            end
            ADDR_W'(OFS_WINDOW): bus_rdata = '0;
            default:             bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wd_rst,
    input logic              early_irq,
    input logic              running,
    input logic              unlocked,
    input logic              ack_wr,
    input logic              div_wr_req,
    input logic              div_busy,
    input logic              rl_busy,
    input logic [CODE_W-1:0] div_staged
);

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wd_rst |=> !wd_rst); // R5
    AST_RST_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> !wd_rst); // R5
    AST_IDLE_NO_RST: assert property (@(posedge clk) disable iff (!rst_n) !running |=> !wd_rst); // R4
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) running |=> running); // R7
    AST_LOCKED_DIV: assert property (@(posedge clk) disable iff (!rst_n) (div_wr_req && !unlocked) |=> $stable(div_staged)); // R2
    AST_DIV_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (div_busy && !tick) |=> div_busy); // R8
    AST_RLD_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rl_busy && !tick) |=> rl_busy); // R9
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (early_irq && !ack_wr) |=> early_irq); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ack_wr && !tick) |=> !early_irq); // R11

endmodule

bind keyed_wdt keyed_wdt_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wd_rst     (wd_rst),
    .early_irq  (early_irq),
    .running    (running),
    .unlocked   (unlocked),
    .ack_wr     (ack_wr),
    .div_wr_req (div_wr_req),
    .div_busy   (div_busy),
    .rl_busy    (rl_busy),
    .div_staged (div_staged)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CODE   = 6;
    localparam logic [7:0] A_KEY = 8'h00, A_DIV = 8'h04, A_RLD = 8'h08,
                           A_ST = 8'h0C, A_WIN = 8'h10, A_EW = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wd_rst;
    logic        early_irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdt i_keyed_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wd_rst    (wd_rst),
        .early_irq (early_irq)
    );

    function automatic int exp_div(int code);
        int c = (code > MAX_CODE) ? MAX_CODE : code;
        return 1 << (c + 2);
    endfunction

    function automatic int exp_period(int rl, int code);
        return (rl + 1) * exp_div(code);
    endfunction

    function automatic int exp_warn(int rl, int cmp, int code);
        return (rl - cmp) * exp_div(code);
    endfunction

    task automatic check(string req, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic wr(logic [7:0] addr, logic [15:0] data);
        tick      = 1'b0;
        bus_addr  = addr;
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [7:0] addr, output int v);
        bus_addr = addr;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic run_ticks(int n, output int rst_seen);
        rst_seen = 0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            if (wd_rst) rst_seen++;
        end
        tick = 1'b0;
    endtask

    task automatic measure(int density, output int irq_at, output int rst_at);
        int   n;
        logic prev;
        n = 0;
        prev = early_irq;
        irq_at = -1;
        rst_at = -1;
        for (int cyc = 0; cyc < 20000 && rst_at < 0; cyc++) begin
            bit t;
            t = ($urandom_range(99) < density);
            tick = t;
            @(negedge clk);
            if (t) n++;
            if (early_irq && !prev && irq_at < 0) irq_at = n;
            prev = early_irq;
            if (wd_rst) rst_at = n;
        end
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v, seen, irq_at, rst_at, total;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_DIV, v);  check("R1", "divider code", v, 0);
        rd(A_RLD, v);  check("R1", "reload", v, 12'hFFF);
        rd(A_ST, v);   check("R1", "status", v, 0);
        rd(A_EW, v);   check("R1", "early reg", v, 0);
        check("R1", "wd_rst", int'(wd_rst), 0);
        check("R1", "early_irq", int'(early_irq), 0);
        // R12: key and window offsets read 0
        rd(A_KEY, v);  check("R12", "key read", v, 0);
        rd(A_WIN, v);  check("R12", "window read", v, 0);

        // R2: locked write ignored, unlock accepts
        wr(A_DIV, 16'd2);
        rd(A_DIV, v);  check("R2", "locked div write", v, 0);
        wr(A_KEY, 16'h5555);
        wr(A_DIV, 16'd2);
        rd(A_DIV, v);  check("R2", "unlocked div write", v, 2);
        // R8: busy for three ticks
        rd(A_ST, v);   check("R8", "div busy set", v & 1, 1);
        run_ticks(2, seen);
        rd(A_ST, v);   check("R8", "div busy after 2 ticks", v & 1, 1);
        run_ticks(1, seen);
        rd(A_ST, v);   check("R8", "div busy after 3 ticks", v & 1, 0);
        wr(A_KEY, 16'h0000);
        wr(A_DIV, 16'd5);
        rd(A_DIV, v);  check("R2", "relocked div write", v, 2);

        // R3: unknown key does not unlock
        wr(A_KEY, 16'h1234);
        wr(A_RLD, 16'd7);
        rd(A_RLD, v);  check("R3", "unknown key unlocked", v, 12'hFFF);
        wr(A_KEY, 16'h5555);
        wr(A_KEY, 16'h1234);
        wr(A_RLD, 16'd5);
        rd(A_RLD, v);  check("R3", "unknown key locked", v, 5);
        // R9: reload busy
        rd(A_ST, v);   check("R9", "reload busy set", (v >> 1) & 1, 1);
        run_ticks(3, seen);
        rd(A_ST, v);   check("R9", "reload busy after 3 ticks", (v >> 1) & 1, 0);
        check("R3", "no start by unknown key", seen, 0);
        run_ticks(200, seen);
        check("R3", "still stopped after ticks", seen, 0);

        // R4/R5: start and expiry timing, divide 4, reload 5
        wr(A_DIV, 16'd0);
        run_ticks(3, seen);
        wr(A_KEY, 16'h0000);
        wr(A_KEY, 16'hCCCC);
        measure(100, irq_at, rst_at);
        check("R4", "first expiry ticks", rst_at, exp_period(5, 0));
        tick = 1'b0;
        @(negedge clk);
        check("R5", "reset pulse one cycle", int'(wd_rst), 0);
        measure(60, irq_at, rst_at);
        check("R5", "second expiry ticks", rst_at, exp_period(5, 0));

        // R7: no key stops it
        wr(A_KEY, 16'h0000);
        wr(A_KEY, 16'h5555);
        wr(A_KEY, 16'h1234);
        wr(A_KEY, 16'h0000);
        measure(80, irq_at, rst_at);
        check("R7", "still running after keys", rst_at, exp_period(5, 0));

        // R6: servicing prevents reset and clears phase
        total = 0;
        for (int k = 0; k < 5; k++) begin
            run_ticks(22, seen);
            total += seen;
            wr(A_KEY, 16'hAAAA);
        end
        check("R6", "resets while serviced", total, 0);
        measure(100, irq_at, rst_at);
        check("R6", "period after service", rst_at, exp_period(5, 0));

        // R10/R11: early warning at compare 3
        wr(A_KEY, 16'h5555);
        wr(A_EW, 16'h8003);
        rd(A_EW, v);   check("R10", "early reg readback", v, 16'h8003);
        wr(A_KEY, 16'h0000);
        wr(A_KEY, 16'hAAAA);
        measure(100, irq_at, rst_at);
        check("R10", "warning ticks", irq_at, exp_warn(5, 3, 0));
        check("R10", "expiry with warning", rst_at, exp_period(5, 0));
        check("R10", "warning held", int'(early_irq), 1);
        wr(A_EW, 16'h4000);
        check("R11", "ack while locked", int'(early_irq), 0);
        rd(A_EW, v);   check("R2", "locked early fields", v, 16'h8003);

        // R4: top code clamps to divide 256, warning disabled
        wr(A_KEY, 16'h5555);
        wr(A_DIV, 16'd7);
        wr(A_RLD, 16'd2);
        wr(A_EW, 16'h0001);
        rd(A_DIV, v);  check("R4", "code 7 readback", v, 7);
        wr(A_KEY, 16'h0000);
        run_ticks(3, seen);
        rd(A_ST, v);   check("R8", "status clear", v, 0);
        wr(A_KEY, 16'hAAAA);
        wr(A_EW, 16'h4000);
        measure(100, irq_at, rst_at);
        check("R4", "clamped divide expiry", rst_at, exp_period(2, 7));
        check("R10", "disabled warning", irq_at, -1);

        // Random configurations
        for (int it = 0; it < 8; it++) begin
            int code, rl, cmp, dens;
            code = int'($urandom_range(2));
            rl   = 2 + int'($urandom_range(13));
            cmp  = int'($urandom_range(rl - 1));
            dens = 30 + int'($urandom_range(70));
            wr(A_KEY, 16'h5555);
            wr(A_DIV, 16'(code));
            wr(A_RLD, 16'(rl));
            wr(A_EW, 16'h8000 | 16'(cmp));
            wr(A_KEY, 16'h0000);
            run_ticks(3, seen);
            rd(A_ST, v);  check("R9", "random status clear", v, 0);
            wr(A_KEY, 16'hAAAA);
            wr(A_EW, 16'h4000);
            check("R11", "random ack", int'(early_irq), 0);
            measure(dens, irq_at, rst_at);
            check("R10", "random warning ticks", irq_at, exp_warn(rl, cmp, code));
            check("R5", "random expiry ticks", rst_at, exp_period(rl, code));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule